// File: doc/BRIEF.md
# Multi-Lane Source-Synchronous Sample Serializer

This block is the transmit half of a converter readout port. A parallel sample word is latched when a frame starts. It is then shifted out on one, two or four data lanes, together with a forwarded strobe clock that the receiver uses to capture the bits. Each lane sends its own contiguous slice of the word, most significant bit first. A small configuration register sets three things: the lane count, single or double data rate, and the strobe source. Lanes that the lane count leaves unused have their output enables turned off, so they float.

The strobe is never a real clock. Both of its sources are one-cycle enable pulses on a single fast system clock. One source is an externally supplied serial-clock tick. The other is an internal divider, restarted at every frame start, so internal-source frames need no external activity. Every accepted tick is one strobe edge. In single rate, each bit occupies one full strobe period and is launched with the rising edge. In double rate, a new bit goes out on every edge, and the rising edges carry the even-numbered bits. A done pulse closes every frame.

The frame engine is a three-state machine. `IDLE` waits for `start` and is the only state that accepts configuration writes. The transition `IDLE -> SHIFT` on `start` latches the word and clears the edge counter. In `SHIFT`, each tick toggles the strobe and advances the counter. The transition `SHIFT -> DONE` happens on the tick that arrives after the final edge. `DONE -> IDLE` follows one cycle later, without condition.

Top module: `lane_serializer`

## Requirements
- R1: After reset: strobe is 0, done is 0, the lane count is one lane (code 0), the rate is single, the source is external, and `sdo_oe` is 4'b0001.
- R2: In IDLE, a write with `cfg_we` stores `cfg_lanes`, `cfg_ddr` and `cfg_src`. Lane code 0 gives 1 lane with `sdo_oe`=4'b0001. Code 1 gives 2 lanes with `sdo_oe`=4'b0011. Code 2 gives 4 lanes with `sdo_oe`=4'b1111. An enabled lane drives 0 while no frame runs, and a disabled lane is high impedance.
- R3: A write that carries lane code 3 leaves all three configuration fields unchanged.
- R4: The strobe is low in IDLE and DONE. During a frame it toggles once per accepted tick and never without one, so its first edge is rising.
- R5: Single rate with N = 16/lanes bits per lane: a frame has 2N strobe edges. Bit k is on the lane from rising edge 2k until rising edge 2k+2.
- R6: Double rate: a frame has N strobe edges. Bit k is on the lane from edge k until edge k+1, where edge 0 is the first rising edge.
- R7: Lane l carries `sample[15 - l*N - k]` as its bit k. So with two lanes, lane 0 sends the upper byte and lane 1 the lower byte. With four lanes, lane 0 sends bits 15..12 and lane 3 sends bits 3..0.
- R8: Between the start cycle and the first tick, each active lane already presents its bit 0; lane 0 shows the word's MSB.
- R9: The tick that follows the last strobe edge ends the frame. `done` is then high for exactly one cycle, and the block returns to IDLE, where the lanes drive 0.
- R10: A `start` pulse during a frame has no effect: the frame keeps its original word and its edge count.
- R11: A configuration write during a frame or in DONE has no effect. `sdo_oe` and the frame format stay as they were.
- R12: With the external source (`cfg_src`=0), only `ext_tick` advances a frame, and a frame without ticks holds its state. With the internal source (`cfg_src`=1), ticks occur every INT_DIV cycles counted from frame start and `ext_tick` is ignored, so `done` rises (T+1)*INT_DIV cycles after the start edge, where T is the frame's edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe, honoured only in IDLE |
| cfg_lanes | input | 2 | Lane count code: 0=1, 1=2, 2=4, 3 reserved |
| cfg_ddr | input | 1 | 1 selects double data rate |
| cfg_src | input | 1 | Strobe source: 0 external tick, 1 internal divider |
| start | input | 1 | Frame start request |
| sample | input | 16 | Word to send, latched at frame start |
| ext_tick | input | 1 | External serial-clock edge enable pulse |
| strobe | output | 1 | Forwarded strobe, idles low |
| sdo | output | 4 | Lane data, high impedance on disabled lanes |
| sdo_oe | output | 4 | Per-lane output enable |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench aims at the lane slicing. If the lane index were mixed up or the slice reversed, two- and four-lane frames would send bytes or nibbles in the wrong order, and random words expose that at once. It checks every phase in single and double rate. A counter that shifted on falling edges, or one that treated double rate as single, would present bits half a period late or make the frame twice as long. It also covers the stall and the exact internal-source length: a divider that ran on through idle, or a mux that let `ext_tick` through in internal mode, would end the frame early or at a varying time. Finally, it fires starts and configuration writes in the middle of frames, which a machine that did not gate on IDLE would restart or reformat.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } ser_state_e;

    localparam int unsigned NUM_LANES = 4;

    localparam logic [1:0] LANES_ONE  = 2'd0;
    localparam logic [1:0] LANES_TWO  = 2'd1;
    localparam logic [1:0] LANES_FOUR = 2'd2;
    localparam logic [1:0] LANES_RSVD = 2'd3;

    // number of active lanes for a stored lane code
    function automatic int unsigned lanes_of(input logic [1:0] code);
        unique case (code)
            LANES_ONE: lanes_of = 1;
            LANES_TWO: lanes_of = 2;
            default:   lanes_of = 4;
        endcase
    endfunction

endpackage

// File: rtl/ser_cfg.sv
module ser_cfg
    import ser_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       idle,
    input  logic [1:0] wr_lanes,
    input  logic       wr_ddr,
    input  logic       wr_src,
    output logic [1:0] lanes_q,
    output logic       ddr_q,
    output logic       src_q
);

    logic accept;

    always_comb begin
        accept = wr_en && idle && (wr_lanes != LANES_RSVD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= LANES_ONE;
            ddr_q   <= 1'b0;
            src_q   <= 1'b0;
        end else if (accept) begin
            lanes_q <= wr_lanes;
            ddr_q   <= wr_ddr;
            src_q   <= wr_src;
        end
    end

endmodule

// File: rtl/ser_tick.sv
module ser_tick #(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic use_int,
    input  logic ext_tick,
    output logic tick
);

    localparam int unsigned DW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;
    logic          int_tick;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        int_tick = (div_q == LAST);
        tick     = use_int ? int_tick : ext_tick;
    end

endmodule

// File: rtl/ser_lanes.sv
module ser_lanes
    import ser_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned IDX_W    = 4
) (
    input  logic [SAMPLE_W-1:0] word,
    input  logic [1:0]          lanes_code,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                active,
    output logic [NUM_LANES-1:0] dat,
    output logic [NUM_LANES-1:0] oe
);

    localparam int unsigned POS_W = $clog2(SAMPLE_W);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        int unsigned n_lanes;
        int unsigned per_lane;
        int          pos;

        always_comb begin
            n_lanes  = lanes_of(lanes_code);
            per_lane = SAMPLE_W / n_lanes;
            pos      = int'(SAMPLE_W) - 1 - l * int'(per_lane) - int'(bit_idx);
            oe[l]    = (l < n_lanes);
            if (active && oe[l] && pos >= 0) begin
                dat[l] = word[POS_W'(pos)];
            end else begin
                dat[l] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/lane_serializer.sv
module lane_serializer
    import ser_pkg::*;
#(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned INT_DIV  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_lanes,
    input  logic                 cfg_ddr,
    input  logic                 cfg_src,
    input  logic                 start,
    input  logic [SAMPLE_W-1:0]  sample,
    input  logic                 ext_tick,
    output logic                 strobe,
    output logic [NUM_LANES-1:0] sdo,
    output logic [NUM_LANES-1:0] sdo_oe,
    output logic                 done
);

    localparam int unsigned CNT_W = $clog2(2 * SAMPLE_W + 1);
    localparam int unsigned IDX_W = $clog2(SAMPLE_W);

    ser_state_e state_q, state_d;

    logic [1:0]           lanes_q;
    logic                 ddr_q;
    logic                 src_q;
    logic                 tick;
    logic                 idle;
    logic [CNT_W-1:0]     cnt_q;
    logic [CNT_W-1:0]     last_cnt;
    logic [CNT_W-1:0]     cnt_m1;
    logic [IDX_W-1:0]     bit_idx;
    logic [SAMPLE_W-1:0]  word_q;
    logic                 strobe_q;
    logic                 lanes_active;
    logic [NUM_LANES-1:0] lane_dat;
    logic [NUM_LANES-1:0] lane_oe;

    ser_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .idle     (idle),
        .wr_lanes (cfg_lanes),
        .wr_ddr   (cfg_ddr),
        .wr_src   (cfg_src),
        .lanes_q  (lanes_q),
        .ddr_q    (ddr_q),
        .src_q    (src_q)
    );

    ser_tick #(.DIV(INT_DIV)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (idle),
        .use_int  (src_q),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    ser_lanes #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_lanes (
        .word       (word_q),
        .lanes_code (lanes_q),
        .bit_idx    (bit_idx),
        .active     (lanes_active),
        .dat        (lane_dat),
        .oe         (lane_oe)
    );

    // edge count of a frame: N bits per lane, two edges per bit in single rate
    always_comb begin
        if (ddr_q) begin
            last_cnt = CNT_W'(SAMPLE_W >> lanes_q);
        end else begin
            last_cnt = CNT_W'((2 * SAMPLE_W) >> lanes_q);
        end
        cnt_m1 = cnt_q - 1'b1;
        if (cnt_q == '0) begin
            bit_idx = '0;
        end else if (ddr_q) begin
            bit_idx = IDX_W'(cnt_m1);
        end else begin
            bit_idx = IDX_W'(cnt_m1 >> 1);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick && (cnt_q == last_cnt)) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // datapath: word latch, edge counter, strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q    <= '0;
                    strobe_q <= 1'b0;
                    if (start) begin
                        word_q <= sample;
                    end
                end
                ST_SHIFT: begin
                    if (tick && (cnt_q != last_cnt)) begin
                        cnt_q    <= cnt_q + 1'b1;
                        strobe_q <= ~strobe_q;
                    end
                end
                ST_DONE: begin
                    cnt_q    <= '0;
                    strobe_q <= 1'b0;
                end
                default: begin
                    cnt_q    <= '0;
                    strobe_q <= 1'b0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        idle         = (state_q == ST_IDLE);
        lanes_active = (state_q == ST_SHIFT);
        done         = (state_q == ST_DONE);
        strobe       = strobe_q;
        sdo_oe       = lane_oe;
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_pad
        assign sdo[l] = lane_oe[l] ? lane_dat[l] : 1'bz;
    end

endmodule

// File: rtl/ser_chk.sv
module ser_chk
    import ser_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input ser_state_e           state_q,
    input logic                 tick,
    input logic                 strobe,
    input logic                 done,
    input logic [1:0]           lanes_q,
    input logic                 ddr_q,
    input logic                 src_q,
    input logic [NUM_LANES-1:0] sdo_oe
);

    AST_IDLE_STROBE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !strobe); // R4

    AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(strobe)); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_FROM_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == ST_SHIFT)); // R9

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(lanes_q) && $stable(ddr_q) && $stable(src_q))); // R11

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |=> (state_q != ST_IDLE)); // R10

    AST_OE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe == 4'b0001) || (sdo_oe == 4'b0011) || (sdo_oe == 4'b1111)); // R2

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        lanes_q != LANES_RSVD); // R3

endmodule

bind lane_serializer ser_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .tick    (tick),
    .strobe  (strobe),
    .done    (done),
    .lanes_q (lanes_q),
    .ddr_q   (ddr_q),
    .src_q   (src_q),
    .sdo_oe  (sdo_oe)
);

// File: tb/lane_serializer_tb.sv
module lane_serializer_tb;

    localparam int INT_DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_lanes = 2'd0;
    logic        cfg_ddr = 1'b0;
    logic        cfg_src = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sample = 16'h0;
    logic        ext_tick = 1'b0;
    logic        strobe;
    logic [3:0]  sdo;
    logic [3:0]  sdo_oe;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lane_serializer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_lanes (cfg_lanes),
        .cfg_ddr   (cfg_ddr),
        .cfg_src   (cfg_src),
        .start     (start),
        .sample    (sample),
        .ext_tick  (ext_tick),
        .strobe    (strobe),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nlanes(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic logic [3:0] exp_oe(input int code);
        return (code == 0) ? 4'b0001 : (code == 1) ? 4'b0011 : 4'b1111;
    endfunction

    function automatic logic exp_bit(input logic [15:0] w, input int code, input int lane, input int b);
        int n = 16 / nlanes(code);
        return w[15 - lane * n - b];
    endfunction

    task automatic set_cfg(input int code, input bit ddr, input bit src);
        cfg_we = 1'b1; cfg_lanes = 2'(code); cfg_ddr = ddr; cfg_src = src;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_tick();
        ext_tick = 1'b1;
        @(negedge clk);
        ext_tick = 1'b0;
    endtask

    task automatic check_lanes(input logic [15:0] w, input int code, input int b, input string req);
        for (int l = 0; l < nlanes(code); l++) begin
            chk(sdo[l] === exp_bit(w, code, l, b), req, int'(sdo[l]), int'(exp_bit(w, code, l, b)));
        end
    endtask

    // inject: 0 none, 1 start during frame, 2 cfg write during frame
    task automatic run_frame(input logic [15:0] w, input int code, input bit ddr, input int inject);
        int n;
        int t_last;
        set_cfg(code, ddr, 1'b0);
        chk(sdo_oe == exp_oe(code), "R2", int'(sdo_oe), int'(exp_oe(code)));
        chk(sdo[0] === 1'b0, "R2", int'(sdo[0]), 0);
        sample = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sample = ~w;
        chk(strobe == 1'b0, "R4", int'(strobe), 0);
        check_lanes(w, code, 0, "R8");
        n = 16 / nlanes(code);
        t_last = ddr ? n : 2 * n;
        for (int t = 1; t <= t_last; t++) begin
            pulse_tick();
            chk(strobe == 1'(t % 2), "R4", int'(strobe), t % 2);
            chk(done == 1'b0, "R9", int'(done), 0);
            if (ddr) check_lanes(w, code, t - 1, "R6 R7");
            else     check_lanes(w, code, (t - 1) / 2, "R5 R7");
            if (t == 3 && inject == 1) begin
                sample = 16'h0; start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                chk(strobe == 1'b1, "R10", int'(strobe), 1);
                check_lanes(w, code, ddr ? 2 : 1, "R10");
            end
            if (t == 3 && inject == 2) begin
                set_cfg((code + 1) % 3, ~ddr, 1'b1);
                chk(sdo_oe == exp_oe(code), "R11", int'(sdo_oe), int'(exp_oe(code)));
            end
        end
        pulse_tick();
        chk(done == 1'b1, "R9", int'(done), 1);
        chk(strobe == 1'b0, "R4", int'(strobe), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9", int'(done), 0);
        chk(sdo[0] === 1'b0, "R9", int'(sdo[0]), 0);
        if (inject == 2) begin
            chk(sdo_oe == exp_oe(code), "R11", int'(sdo_oe), int'(exp_oe(code)));
        end
    endtask

    task automatic run_internal(input int code, input bit ddr);
        int t_last;
        int got;
        set_cfg(code, ddr, 1'b1);
        t_last = ddr ? 16 / nlanes(code) : 32 / nlanes(code);
        ext_tick = 1'b1;
        sample = 16'hA5C3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got = -1;
        for (int k = 1; k <= 400 && got < 0; k++) begin
            @(negedge clk);
            if (done) got = k;
        end
        ext_tick = 1'b0;
        chk(got == (t_last + 1) * INT_DIV, "R12", got, (t_last + 1) * INT_DIV);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(strobe == 1'b0, "R1", int'(strobe), 0);
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(sdo_oe == 4'b0001, "R1", int'(sdo_oe), 1);
        chk(sdo[0] === 1'b0, "R1", int'(sdo[0]), 0);

        // R2 all codes and R3 reserved code
        set_cfg(2, 1'b0, 1'b0);
        chk(sdo_oe == 4'b1111, "R2", int'(sdo_oe), 15);
        set_cfg(1, 1'b0, 1'b0);
        chk(sdo_oe == 4'b0011, "R2", int'(sdo_oe), 3);
        set_cfg(3, 1'b1, 1'b1);
        chk(sdo_oe == 4'b0011, "R3", int'(sdo_oe), 3);
        // a reserved write must not have switched to the internal source: frame stalls without ticks
        sample = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        chk(strobe == 1'b0, "R3 R12", int'(strobe), 0);
        chk(done == 1'b0, "R12", int'(done), 0);
        chk(sdo[0] === 1'b1, "R12", int'(sdo[0]), 1);
        for (int t = 0; t < 17; t++) pulse_tick();
        chk(done == 1'b1, "R3 R5", int'(done), 1);
        @(negedge clk);

        // directed patterns for all six formats
        for (int c = 0; c < 3; c++) begin
            run_frame(16'h8001, c, 1'b0, 0);
            run_frame(16'h1234, c, 1'b1, 0);
        end
        // mid-frame start and config writes
        run_frame(16'hC3A5, 1, 1'b0, 1);
        run_frame(16'h5A0F, 2, 1'b1, 1);
        run_frame(16'h0FF0, 0, 1'b1, 2);
        run_frame(16'h9669, 2, 1'b0, 2);

        // internal source timing, external ticks held high
        run_internal(2, 1'b1);
        run_internal(0, 1'b0);
        run_internal(1, 1'b1);

        // constrained random frames
        for (int i = 0; i < 40; i++) begin
            logic [15:0] w;
            int c;
            bit d;
            w = 16'($urandom);
            c = int'($urandom_range(2, 0));
            d = 1'($urandom);
            run_frame(w, c, d, 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule